// File: doc/BRIEF.md
# Byte-Level I2C Read Master

This block is the bus engine of an I2C master that reads from a slave. Software works through a single byte data register, three request strobes (start, stop and a data-register write) and one level control that chooses the acknowledge for the next received byte. The block reports a receive-full flag, a not-acknowledge flag and an acknowledge flag. On the bus side it drives separate pull-low enables for SCL and SDA and reads SDA back through a synchronizer.

A read with a 7-bit address is a start followed by the address byte with bit 0 set. After the slave acknowledges, data bytes follow. Each received byte sets the receive-full flag, and the block holds SCL low until software reads the byte. Before it reads the second-to-last byte, software raises the acknowledge control so that the final byte is refused. A 10-bit read begins with a write-direction address byte of the form 11110 a9 a8 0, then the low address byte. Software then requests a repeated start with the read form of the first byte, 11110 a9 a8 1. If the slave refuses an address, or after the final refused byte, the not-acknowledge flag is raised and the block waits for a stop request. The stop clears both the stop request and that flag.

The controller is one state machine. Every state lasts a whole number of bit slots, and each slot has four quarters whose length is set by a divider. The states are IDLE, START, TX_BIT, TX_ACK, RX_BIT, RX_ACK, WAIT_TX, WAIT_RX, WAIT_STOP and STOP. All transitions happen at the end of a slot:
- IDLE goes to START on a start request.
- START goes to TX_BIT, and TX_BIT goes to TX_ACK after eight bits.
- From TX_ACK, a released SDA leads to WAIT_STOP. Otherwise bit 0 of the address byte chooses WAIT_RX (read) or WAIT_TX (write).
- WAIT_TX goes to STOP, START or TX_BIT, in that order of priority.
- WAIT_RX goes to STOP, or to RX_BIT once the receive-full flag is clear.
- RX_BIT goes to RX_ACK after eight bits.
- RX_ACK goes to WAIT_STOP if the byte was refused, and to WAIT_RX otherwise.
- WAIT_STOP goes to STOP, and STOP goes to IDLE.

Top module: `iic_read_master`

## Requirements
- R1: After reset both pull-low outputs are released, and rx_full, nack_flag, ack_flag, start_pend, stop_pend and busy are all 0.
- R2: A start request produces a start condition (SDA pulled low while SCL is high) and then sends the data register MSB first. Outside start and stop conditions, SDA changes only while SCL is held low.
- R3: In the acknowledge slot of a sent byte, ack_flag is set to 1 if the slave holds SDA low. If SDA is released, ack_flag is cleared, nack_flag is set, and SCL stays low until a stop request.
- R4: A stop request in WAIT_STOP, WAIT_TX or WAIT_RX produces a stop condition (SDA released while SCL is high). At the end of it, stop_pend and nack_flag are 0 and busy is 0.
- R5: A received byte is 8 bits, MSB first. In the slot that follows, the master pulls SDA low (acknowledge) when nak_next was 0 at the end of the eighth bit, and releases it (refusal) when nak_next was 1.
- R6: After each received byte and its acknowledge slot, rx_full is 1 and dat_rdata holds the byte. A dat_rd pulse clears rx_full.
- R7: While rx_full is 1 during a read, SCL stays low and no further bit is clocked.
- R8: After a byte refused through nak_next, nack_flag becomes 1 and no stop is driven until a stop request arrives.
- R9: After a write-direction byte (bit 0 = 0) is acknowledged, the master holds SCL low. A data write sends the next byte, and a start request issues a repeated start with the data register. A read-direction byte (bit 0 = 1) that is acknowledged leads into receiving.
- R10: A stop request while idle causes no bus activity, and stop_pend returns to 0.
- R11: Each quarter of a bit slot lasts quarter_div+1 clock cycles, so SCL stays high for 2*(quarter_div+1) cycles per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| quarter_div | input | DIV_W | Quarter-bit length minus one, in clock cycles |
| dat_wr | input | 1 | Write pulse for the data register (marks a byte pending to send) |
| dat_wdata | input | BYTE_W | Byte written to the data register |
| dat_rd | input | 1 | Read pulse for the data register; clears rx_full |
| dat_rdata | output | BYTE_W | Data register contents (last received byte) |
| go_start | input | 1 | Start request pulse (sets start_pend) |
| go_stop | input | 1 | Stop request pulse (sets stop_pend) |
| nak_next | input | 1 | 1 = refuse the next received byte |
| rx_full | output | 1 | A received byte is waiting to be read |
| nack_flag | output | 1 | Address refused or final byte refused; cleared by the stop |
| ack_flag | output | 1 | Acknowledge seen on the last sent byte |
| start_pend | output | 1 | Start request not yet carried out |
| stop_pend | output | 1 | Stop request not yet carried out |
| busy | output | 1 | Controller not in IDLE |
| sda_in | input | 1 | SDA level read from the bus |
| scl_drive_low | output | 1 | 1 = pull SCL low |
| sda_drive_low | output | 1 | 1 = pull SDA low |

## Verification
The bench builds the block with DIV_W = 6, BYTE_W = 8 and SYNC_STAGES = 2. It runs the 7-bit read with quarter_div = 3 and the 10-bit read with quarter_div = 1. At the shorter setting, the two-stage synchronizer and the slave's reaction to the SCL fall only just fit inside the two quarters before the master samples, which puts the latency budget under test. The behavioural slave can refuse its address, so the refusal path and the wait for the stop request are also exercised.

// File: rtl/iicr_pkg.sv
package iicr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_TX_BIT,
        ST_TX_ACK,
        ST_RX_BIT,
        ST_RX_ACK,
        ST_WAIT_TX,
        ST_WAIT_RX,
        ST_WAIT_STOP,
        ST_STOP
    } iicr_state_e;

    localparam int QUARTERS = 4;
    localparam int PH_W     = $clog2(QUARTERS);
    typedef logic [PH_W-1:0] iicr_phase_t;
endpackage

// File: rtl/iicr_tick.sv
module iicr_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/iicr_sync.sv
module iicr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [DEPTH-1:0] sr;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[DEPTH-2:0], d[g]};
        end
        assign q[g] = sr[DEPTH-1];
    end
endmodule

// File: rtl/iic_read_master.sv
module iic_read_master
    import iicr_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  quarter_div,
    input  logic              dat_wr,
    input  logic [BYTE_W-1:0] dat_wdata,
    input  logic              dat_rd,
    output logic [BYTE_W-1:0] dat_rdata,
    input  logic              go_start,
    input  logic              go_stop,
    input  logic              nak_next,
    output logic              rx_full,
    output logic              nack_flag,
    output logic              ack_flag,
    output logic              start_pend,
    output logic              stop_pend,
    output logic              busy,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    localparam int                CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(BYTE_W - 1);
    localparam iicr_phase_t       PH_SET = iicr_phase_t'(1);
    localparam iicr_phase_t       PH_SMP = iicr_phase_t'(2);
    localparam iicr_phase_t       PH_END = iicr_phase_t'(QUARTERS - 1);

    iicr_state_e       state, nstate;
    iicr_phase_t       phase, nphase;
    logic              tick, slot_end, sda_s;
    logic [BYTE_W-1:0] shreg, data_q;
    logic [CNT_W-1:0]  bitcnt;
    logic              tx_pend, rdrf, start_q, stop_q, ncki, ack_q;
    logic              nak_lat, rd_mode, samp;
    logic              scl_q, sda_q;

    iicr_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (quarter_div),
        .tick (tick)
    );

    iicr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sda_in),
        .q    (sda_s)
    );

    assign slot_end = tick && (phase == PH_END);
    assign nphase   = tick ? phase + iicr_phase_t'(1) : phase;

    // next-state decision, taken only at the end of a bit slot
    always_comb begin
        nstate = state;
        if (slot_end) begin
            unique case (state)
                ST_IDLE:      if (start_q) nstate = ST_START;
                ST_START:     nstate = ST_TX_BIT;
                ST_TX_BIT:    if (bitcnt == LAST) nstate = ST_TX_ACK;
                ST_TX_ACK:    if (samp)         nstate = ST_WAIT_STOP;
                              else if (rd_mode) nstate = ST_WAIT_RX;
                              else              nstate = ST_WAIT_TX;
                ST_RX_BIT:    if (bitcnt == LAST) nstate = ST_RX_ACK;
                ST_RX_ACK:    nstate = nak_lat ? ST_WAIT_STOP : ST_WAIT_RX;
                ST_WAIT_TX:   if (stop_q)       nstate = ST_STOP;
                              else if (start_q) nstate = ST_START;
                              else if (tx_pend) nstate = ST_TX_BIT;
                ST_WAIT_RX:   if (stop_q)       nstate = ST_STOP;
                              else if (!rdrf)   nstate = ST_RX_BIT;
                ST_WAIT_STOP: if (stop_q) nstate = ST_STOP;
                ST_STOP:      nstate = ST_IDLE;
                default:      nstate = ST_IDLE;
            endcase
        end
    end

    // state register with the byte datapath and software-visible bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= '0;
            shreg   <= '0;
            data_q  <= '0;
            bitcnt  <= '0;
            tx_pend <= 1'b0;
            rdrf    <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            ncki    <= 1'b0;
            ack_q   <= 1'b0;
            nak_lat <= 1'b0;
            rd_mode <= 1'b0;
            samp    <= 1'b0;
        end else begin
            state <= nstate;
            phase <= nphase;
            if (go_start) start_q <= 1'b1;
            if (go_stop)  stop_q  <= 1'b1;
            if (dat_wr) begin
                data_q  <= dat_wdata;
                tx_pend <= 1'b1;
            end
            if (dat_rd) rdrf <= 1'b0;
            if (tick && phase == PH_SMP) begin
                if (state == ST_RX_BIT) shreg <= {shreg[BYTE_W-2:0], sda_s};
                if (state == ST_TX_ACK) samp  <= sda_s;
            end
            if (slot_end) begin
                case (state)
                    ST_IDLE: if (!start_q && stop_q) stop_q <= 1'b0;
                    ST_START: begin
                        start_q <= 1'b0;
                        shreg   <= data_q;
                        rd_mode <= data_q[0];
                        tx_pend <= 1'b0;
                        bitcnt  <= '0;
                    end
                    ST_TX_BIT: begin
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                    ST_TX_ACK: begin
                        ack_q <= ~samp;
                        if (samp) ncki <= 1'b1;
                    end
                    ST_RX_BIT: begin
                        bitcnt <= bitcnt + CNT_W'(1);
                        if (bitcnt == LAST) nak_lat <= nak_next;
                    end
                    ST_RX_ACK: begin
                        data_q <= shreg;
                        rdrf   <= 1'b1;
                        if (nak_lat) ncki <= 1'b1;
                    end
                    ST_WAIT_TX: if (!stop_q && !start_q && tx_pend) begin
                        shreg   <= data_q;
                        tx_pend <= 1'b0;
                        bitcnt  <= '0;
                    end
                    ST_WAIT_RX: bitcnt <= '0;
                    ST_STOP: begin
                        stop_q <= 1'b0;
                        ncki   <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // pad drive: SCL low in quarters 0-1, SDA updated in quarter 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b0;
            sda_q <= 1'b0;
        end else if (tick) begin
            unique case (nstate)
                ST_IDLE: begin
                    scl_q <= 1'b0;
                    sda_q <= 1'b0;
                end
                ST_START: begin
                    scl_q <= ~nphase[PH_W-1];
                    if (nphase == PH_SET)      sda_q <= 1'b0;
                    else if (nphase == PH_END) sda_q <= 1'b1;
                end
                ST_STOP: begin
                    scl_q <= ~nphase[PH_W-1];
                    if (nphase == PH_SET)      sda_q <= 1'b1;
                    else if (nphase == PH_END) sda_q <= 1'b0;
                end
                ST_TX_BIT: begin
                    scl_q <= ~nphase[PH_W-1];
                    if (nphase == PH_SET) sda_q <= ~shreg[BYTE_W-1];
                end
                ST_TX_ACK, ST_RX_BIT: begin
                    scl_q <= ~nphase[PH_W-1];
                    if (nphase == PH_SET) sda_q <= 1'b0;
                end
                ST_RX_ACK: begin
                    scl_q <= ~nphase[PH_W-1];
                    if (nphase == PH_SET) sda_q <= ~nak_lat;
                end
                ST_WAIT_TX, ST_WAIT_RX, ST_WAIT_STOP: begin
                    scl_q <= 1'b1;
                    if (nphase == PH_SET) sda_q <= 1'b0;
                end
                default: begin
                    scl_q <= 1'b0;
                    sda_q <= 1'b0;
                end
            endcase
        end
    end

    assign scl_drive_low = scl_q;
    assign sda_drive_low = sda_q;
    assign dat_rdata     = data_q;
    assign rx_full       = rdrf;
    assign nack_flag     = ncki;
    assign ack_flag      = ack_q;
    assign start_pend    = start_q;
    assign stop_pend     = stop_q;
    assign busy          = (state != ST_IDLE);
endmodule

// File: rtl/iicr_checker.sv
module iicr_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_low,
    input logic sda_low,
    input logic rx_full,
    input logic nack,
    input logic start_pend,
    input logic stop_pend,
    input logic busy
);
    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && $past(!scl_low) && $rose(sda_low)) |-> start_pend);

    // R4
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && $past(!scl_low) && $fell(sda_low)) |-> stop_pend);

    // R6
    rdrf_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> scl_low);

    // R7
    rdrf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |=> scl_low);

    // R8
    nack_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> scl_low);

    // R4
    nack_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(nack) || $fell(stop_pend)) |-> !busy);
endmodule

bind iic_read_master iicr_checker i_iicr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low),
    .rx_full   (rx_full),
    .nack      (nack_flag),
    .start_pend(start_pend),
    .stop_pend (stop_pend),
    .busy      (busy)
);

// File: tb/test_iic_read_master.sv
`timescale 1ns/1ps
module test_iic_read_master;
    localparam int DIV_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] quarter_div = DIV_W'(3);
    logic             dat_wr = 1'b0, dat_rd = 1'b0, go_start = 1'b0, go_stop = 1'b0, nak_next = 1'b0;
    logic [7:0]       dat_wdata = 8'h00;
    logic [7:0]       dat_rdata;
    logic             rx_full, nack_flag, ack_flag, start_pend, stop_pend, busy;
    logic             scl_drive_low, sda_drive_low;
    logic             slv_low = 1'b0;
    logic             sclb, sdab;

    assign sclb = ~scl_drive_low;
    assign sdab = ~(sda_drive_low | slv_low);

    always #2.5 clk = ~clk;

    iic_read_master #(.DIV_W(DIV_W), .BYTE_W(8), .SYNC_STAGES(2)) i_iic_read_master (
        .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
        .go_start(go_start), .go_stop(go_stop), .nak_next(nak_next),
        .rx_full(rx_full), .nack_flag(nack_flag), .ack_flag(ack_flag),
        .start_pend(start_pend), .stop_pend(stop_pend), .busy(busy),
        .sda_in(sdab), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural slave and bus monitor, evaluated every clock
    logic [7:0] slv_bytes[$];
    bit         mack[$];
    int         n_start = 0, n_stop = 0, n_rise = 0, hi_cnt = 0, last_hi = 0, bad_edge = 0;
    int         bitn = 0;
    bit         pscl = 1, psda = 1, slv_tx = 0, first = 0, go_tx = 0, addr_ack_en = 1;
    logic [7:0] rx_sh = 8'h00, tx_sh = 8'h00, slv_val = 8'h3C;

    always @(posedge clk) begin
        if (!rst_n) begin
            pscl = 1; psda = 1; bitn = 0; slv_tx = 0; go_tx = 0; first = 0;
            slv_low <= 1'b0;
        end else begin
            if (sclb) hi_cnt++;
            else begin
                if (hi_cnt > 0 && hi_cnt < 100) last_hi = hi_cnt;
                hi_cnt = 0;
            end
            if (pscl && sclb && psda && !sdab) begin
                n_start++; bitn = 0; first = 1; slv_tx = 0; go_tx = 0;
                slv_low <= 1'b0;
            end else if (pscl && sclb && !psda && sdab) begin
                n_stop++; bitn = 0; slv_tx = 0;
                slv_low <= 1'b0;
            end else if (!pscl && sclb) begin
                n_rise++;
                if (bitn < 8) rx_sh = {rx_sh[6:0], sdab};
                else if (slv_tx) mack.push_back(!sdab);
                bitn++;
            end else if (pscl && !sclb) begin
                if (bitn == 8) begin
                    if (slv_tx) slv_low <= 1'b0;
                    else begin
                        slv_bytes.push_back(rx_sh);
                        if (first) begin
                            slv_low <= addr_ack_en;
                            go_tx = addr_ack_en && rx_sh[0];
                            first = 0;
                        end else slv_low <= 1'b1;
                    end
                end else if (bitn == 9) begin
                    bitn = 0;
                    if (slv_tx && mack.size() > 0 && !mack[mack.size()-1]) slv_tx = 0;
                    if (go_tx) begin slv_tx = 1; go_tx = 0; end
                    if (slv_tx) begin
                        tx_sh = slv_val;
                        slv_val = slv_val + 8'h25;
                        slv_low <= ~tx_sh[7];
                    end else slv_low <= 1'b0;
                end else if (slv_tx && bitn > 0 && bitn < 8) begin
                    slv_low <= ~tx_sh[7-bitn];
                end
            end else if (sclb && pscl && (psda != sdab)) begin
                bad_edge++;
            end
            pscl = sclb; psda = sdab;
        end
    end

    function automatic logic [7:0] exp_byte(input int k);
        return 8'(8'h3C + 8'h25 * k);
    endfunction

    task automatic pulse_wr(input logic [7:0] v);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
        @(negedge clk); dat_wr = 1'b0;
    endtask
    task automatic pulse_start();
        @(negedge clk); go_start = 1'b1;
        @(negedge clk); go_start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); go_stop = 1'b1;
        @(negedge clk); go_stop = 1'b0;
    endtask
    task automatic pulse_rd();
        @(negedge clk); dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
    endtask
    task automatic wait_rx();
        while (!rx_full) @(negedge clk);
    endtask
    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R4: actual=hung expected=idle");
        finish_run();
    end

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl", scl_drive_low, 0);
        chk("R1 sda", sda_drive_low, 0);
        chk("R1 flags", {rx_full, nack_flag, ack_flag, start_pend, stop_pend, busy}, 0);

        // R10 stop while idle
        pulse_stop();
        repeat (40) @(negedge clk);
        chk("R10 stop_pend", stop_pend, 0);
        chk("R10 bus quiet", n_start + n_stop + n_rise, 0);
        chk("R10 busy", busy, 0);

        // 7-bit read of three bytes, quarter_div = 3
        pulse_wr(8'hA1);
        pulse_start();
        wait_rx();
        chk("R2 address byte", slv_bytes[0], 8'hA1);
        chk("R2 one start", n_start, 1);
        chk("R3 ack_flag", ack_flag, 1);
        chk("R6 first byte", dat_rdata, exp_byte(0));
        r0 = n_rise;
        repeat (120) @(negedge clk);
        chk("R7 no clocks while full", n_rise, r0);
        chk("R7 scl held", scl_drive_low, 1);
        pulse_rd();
        chk("R6 cleared by read", rx_full, 0);
        wait_rx();
        chk("R6 second byte", dat_rdata, exp_byte(1));
        nak_next = 1'b1;
        pulse_rd();
        wait_rx();
        chk("R6 third byte", dat_rdata, exp_byte(2));
        chk("R8 nack after last", nack_flag, 1);
        repeat (80) @(negedge clk);
        chk("R8 waits for stop", {busy, 8'(n_stop)}, {1'b1, 8'd0});
        chk("R5 acks sent", {mack[0], mack[1], mack[2]}, 3'b110);
        pulse_rd();
        nak_next = 1'b0;
        pulse_stop();
        wait_idle();
        chk("R4 nack cleared", nack_flag, 0);
        chk("R4 stop_pend cleared", stop_pend, 0);
        chk("R4 stop seen", n_stop, 1);
        chk("R11 scl high div3", last_hi, 8);

        // address refused
        addr_ack_en = 0;
        pulse_wr(8'hA1);
        pulse_start();
        while (!nack_flag) @(negedge clk);
        chk("R3 ack_flag cleared", ack_flag, 0);
        chk("R3 no byte", rx_full, 0);
        repeat (60) @(negedge clk);
        chk("R3 held until stop", {busy, scl_drive_low}, 2'b11);
        pulse_stop();
        wait_idle();
        chk("R4 nack cleared after stop", nack_flag, 0);
        chk("R4 second stop", n_stop, 2);

        // 10-bit read, quarter_div = 1
        addr_ack_en = 1;
        quarter_div = DIV_W'(1);
        pulse_wr(8'hF2);
        pulse_start();
        while (!ack_flag) @(negedge clk);
        pulse_wr(8'h34);
        while (slv_bytes.size() < 4) @(negedge clk);
        pulse_wr(8'hF3);
        pulse_start();
        wait_rx();
        chk("R9 first addr", slv_bytes[2], 8'hF2);
        chk("R9 low addr", slv_bytes[3], 8'h34);
        chk("R9 read addr", slv_bytes[4], 8'hF3);
        chk("R9 repeated start", n_start, 4);
        chk("R9 first data", dat_rdata, exp_byte(3));
        nak_next = 1'b1;
        pulse_rd();
        wait_rx();
        chk("R5 last data", dat_rdata, exp_byte(4));
        chk("R8 nack 10-bit", nack_flag, 1);
        pulse_rd();
        nak_next = 1'b0;
        pulse_stop();
        wait_idle();
        chk("R5 acks 10-bit", {mack[3], mack[4]}, 2'b10);
        chk("R5 ack count", mack.size(), 5);
        chk("R11 scl high div1", last_hi, 4);
        chk("R2 sda only moves with scl low", bad_edge, 0);
        chk("R4 final flags", {nack_flag, stop_pend, busy}, 0);
        finish_run();
    end
endmodule